// File: doc/BRIEF.md
# Expansion Bus Write Snooper

This block sits on the expansion bus of an 8-bit or 16-bit microcomputer and never drives it. A fast sample clock oversamples the bus clock PH0. The block finds each PH0 falling edge and, for every CPU write aimed at the text display pages or at the I/O page, emits a one-clock event that carries the address, the data byte, the memory bank (main or auxiliary) and a text-page flag. A display pipeline downstream builds the text screen from these events.

When the data byte is taken depends on the host model. On the early host, slot data settles late, so the byte is taken a parameterised number of sample clocks after the edge. On the later 8-bit host and on the 16-bit host, the byte is taken at the edge itself. On the 16-bit host a later sample would be wrong, because the bank address appears on the data bus shortly after the edge. Writes to the display soft-switch block update a mode register. The update is held back a model-dependent number of bus cycles, so that it lines up with the host's own video pipeline.

Top module: `bus_snoop_capture`

## Requirements
- R1: PH0 passes through a two-flop synchroniser. Each detected falling edge starts exactly one capture, and `wr_valid_o` is never high for two clocks in a row.
- R2: For `model_i` codes 1 (later 8-bit host), 2 (16-bit host) and 3, address, R/W, bank and data are all taken on the same sample-clock edge: the first edge after the fall is seen at the synchroniser output. A data value that appears after that edge is not captured.
- R3: For `model_i` code 0 (early host), address, R/W and bank are taken at the detected edge. The data byte is taken EARLY_DELAY sample clocks later (default 3).
- R4: An event is emitted only for a write (`rw_i` low) whose address lies in 0x0400–0x07FF or 0xC000–0xC0FF. Reads and writes to any other address produce no event.
- R5: `wr_text_o` is 1 exactly when the event address lies in 0x0400–0x07FF. `wr_aux_o` repeats `aux_i` (1 = auxiliary bank) as sampled with the address.
- R6: A write to 0xC050–0xC05F sets bit addr[3:1] of the mode register to addr[0]. The data byte has no effect on it.
- R7: A mode update is applied at the 2nd following detected PH0 fall on the early host and at the 3rd on all other models. `mode_upd_o` pulses for one clock after it is applied.
- R8: After reset, every output is zero.
- R9: Soft-switch writes in consecutive bus cycles are each applied, in order, at their own scheduled fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, much faster than PH0 |
| rst_ni | input | 1 | Asynchronous reset, active low |
| model_i | input | 2 | Host model: 0 early, 1 later 8-bit, 2 16-bit, 3 treated as later; held stable outside reset |
| ph0_i | input | 1 | Bus clock PH0, asynchronous to clk_i |
| addr_i | input | 16 | Bus address |
| data_i | input | DATA_W | Bus data |
| rw_i | input | 1 | 1 = read, 0 = write |
| aux_i | input | 1 | 1 = auxiliary memory bank selected |
| wr_valid_o | output | 1 | One-clock pulse for a captured write event |
| wr_addr_o | output | 16 | Address of the last event |
| wr_data_o | output | DATA_W | Data of the last event |
| wr_aux_o | output | 1 | Bank of the last event |
| wr_text_o | output | 1 | Last event hit the text window |
| mode_o | output | 8 | Display mode register |
| mode_upd_o | output | 1 | One-clock pulse after a mode update |

## Verification
Two functions can fall on the same clock edge. On the later models a PH0 fall captures a new soft-switch write while the same edge shifts the delay line and applies an older update. The bench provokes this with soft-switch writes in back-to-back bus cycles. Its scoreboard holds the scheduled mode changes, and it compares `mode_o` with them at the end of every bus cycle. The capture instant is judged with a late-settling data bus and with a bus whose byte is replaced by a bank value after the fall. The expected byte follows from the model rule alone.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

    localparam int ADDR_W   = 16;
    localparam int SW_IDX_W = 3;
    localparam int MODE_W   = 1 << SW_IDX_W;

    localparam logic [ADDR_W-1:0] TEXT_FIRST = 16'h0400;
    localparam logic [ADDR_W-1:0] TEXT_LAST  = 16'h07FF;
    localparam logic [7:0]        IO_PAGE    = 8'hC0;
    localparam logic [11:0]       SW_BLOCK   = 12'hC05;

    typedef enum logic [1:0] {
        HOST_EARLY = 2'd0,
        HOST_LATER = 2'd1,
        HOST_WIDE  = 2'd2,
        HOST_SPARE = 2'd3
    } host_e;

    typedef struct packed {
        logic                vld;
        logic [SW_IDX_W-1:0] idx;
        logic                val;
    } sw_upd_t;

endpackage

// File: rtl/snoop_edge_sync.sv
module snoop_edge_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ph0_i,
    output logic fall_o
);
    typedef struct packed {
        logic [SYNC_N:0] sh;
    } st_t;

    st_t d, q;

    always_comb begin
        d    = q;
        d.sh = {q.sh[SYNC_N-1:0], ph0_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign fall_o = q.sh[SYNC_N] & ~q.sh[SYNC_N-1];

    // R1: a detected fall never lasts two clocks
    assert_fall_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> !fall_o);

endmodule

// File: rtl/snoop_capture.sv
module snoop_capture
    import snoop_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int EARLY_DELAY = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fall_i,
    input  logic [1:0]        model_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              rw_i,
    input  logic              aux_i,
    output logic              ev_vld_o,
    output logic [ADDR_W-1:0] ev_addr_o,
    output logic [DATA_W-1:0] ev_data_o,
    output logic              ev_aux_o,
    output logic              ev_text_o,
    output sw_upd_t           sw_o
);
    localparam int CNT_W = $clog2(EARLY_DELAY + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] h_addr;
        logic              h_rw;
        logic              h_aux;
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic              ev_vld;
        logic [ADDR_W-1:0] ev_addr;
        logic [DATA_W-1:0] ev_data;
        logic              ev_aux;
        logic              ev_text;
        sw_upd_t           ev_sw;
    } st_t;

    st_t d, q;
    logic              take;
    logic [ADDR_W-1:0] t_addr;
    logic              t_rw, t_aux;
    logic              hit_text, hit_io, hit_sw;

    always_comb begin
        d            = q;
        d.ev_vld     = 1'b0;
        d.ev_sw.vld  = 1'b0;
        take         = 1'b0;
        t_addr       = q.h_addr;
        t_rw         = q.h_rw;
        t_aux        = q.h_aux;
        if (fall_i) begin
            if (host_e'(model_i) == HOST_EARLY) begin
                d.h_addr = addr_i;
                d.h_rw   = rw_i;
                d.h_aux  = aux_i;
                d.busy   = 1'b1;
                d.cnt    = CNT_W'(EARLY_DELAY);
            end else begin
                take   = 1'b1;
                t_addr = addr_i;
                t_rw   = rw_i;
                t_aux  = aux_i;
            end
        end else if (q.busy) begin
            if (q.cnt == CNT_W'(1)) begin
                d.busy = 1'b0;
                d.cnt  = '0;
                take   = 1'b1;
            end else begin
                d.cnt = q.cnt - CNT_W'(1);
            end
        end
        hit_text = (t_addr >= TEXT_FIRST) && (t_addr <= TEXT_LAST);
        hit_io   = (t_addr[ADDR_W-1:8] == IO_PAGE);
        hit_sw   = (t_addr[ADDR_W-1:4] == SW_BLOCK);
        if (take && !t_rw && (hit_text || hit_io)) begin
            d.ev_vld     = 1'b1;
            d.ev_addr    = t_addr;
            d.ev_data    = data_i;
            d.ev_aux     = t_aux;
            d.ev_text    = hit_text;
            d.ev_sw.vld  = hit_sw;
            d.ev_sw.idx  = t_addr[SW_IDX_W:1];
            d.ev_sw.val  = t_addr[0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign ev_vld_o  = q.ev_vld;
    assign ev_addr_o = q.ev_addr;
    assign ev_data_o = q.ev_data;
    assign ev_aux_o  = q.ev_aux;
    assign ev_text_o = q.ev_text;
    assign sw_o      = q.ev_sw;

    assert_one_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.ev_vld |=> !q.ev_vld);

    assert_count_live_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.busy |-> (q.cnt != '0));

    assert_hit_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.ev_vld |-> ((q.ev_addr[ADDR_W-1:8] == IO_PAGE) ||
                      (q.ev_addr >= TEXT_FIRST && q.ev_addr <= TEXT_LAST)));

endmodule

// File: rtl/snoop_mode_pipe.sv
module snoop_mode_pipe
    import snoop_pkg::*;
#(
    parameter int EARLY_LAG = 2,
    parameter int LATE_LAG  = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fall_i,
    input  logic [1:0]        model_i,
    input  sw_upd_t           sw_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              upd_o
);
    localparam int PIPE_N = LATE_LAG - 1;
    localparam int TAP_E  = EARLY_LAG - 2;
    localparam int TAP_L  = LATE_LAG - 2;

    typedef struct packed {
        sw_upd_t                pend;
        sw_upd_t [PIPE_N-1:0]   pipe;
        logic    [MODE_W-1:0]   mode;
        logic                   upd;
    } st_t;

    st_t     d, q;
    sw_upd_t tap;

    always_comb begin
        d     = q;
        d.upd = 1'b0;
        tap   = (host_e'(model_i) == HOST_EARLY) ? q.pipe[TAP_E] : q.pipe[TAP_L];
        if (fall_i) begin
            if (tap.vld) begin
                d.mode[tap.idx] = tap.val;
                d.upd           = 1'b1;
            end
            d.pipe[0] = q.pend;
            for (int i = 1; i < PIPE_N; i++) begin
                d.pipe[i] = q.pipe[i-1];
            end
            d.pend.vld = 1'b0;
        end
        if (sw_i.vld) begin
            d.pend = sw_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign mode_o = q.mode;
    assign upd_o  = q.upd;

    // R7: updates land only on a PH0 fall seen by the synchroniser
    assert_upd_on_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.upd |-> $past(fall_i));

    assert_mode_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fall_i |=> $stable(q.mode));

endmodule

// File: rtl/bus_snoop_capture.sv
module bus_snoop_capture
    import snoop_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int EARLY_DELAY = 3,
    parameter int SYNC_N      = 2,
    parameter int EARLY_LAG   = 2,
    parameter int LATE_LAG    = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        model_i,
    input  logic              ph0_i,
    input  logic [15:0]       addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              rw_i,
    input  logic              aux_i,
    output logic              wr_valid_o,
    output logic [15:0]       wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              wr_aux_o,
    output logic              wr_text_o,
    output logic [7:0]        mode_o,
    output logic              mode_upd_o
);
    logic    fall;
    sw_upd_t sw;

    snoop_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ph0_i  (ph0_i),
        .fall_o (fall)
    );

    snoop_capture #(.DATA_W(DATA_W), .EARLY_DELAY(EARLY_DELAY)) u_cap (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fall_i    (fall),
        .model_i   (model_i),
        .addr_i    (addr_i),
        .data_i    (data_i),
        .rw_i      (rw_i),
        .aux_i     (aux_i),
        .ev_vld_o  (wr_valid_o),
        .ev_addr_o (wr_addr_o),
        .ev_data_o (wr_data_o),
        .ev_aux_o  (wr_aux_o),
        .ev_text_o (wr_text_o),
        .sw_o      (sw)
    );

    snoop_mode_pipe #(.EARLY_LAG(EARLY_LAG), .LATE_LAG(LATE_LAG)) u_mode (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .fall_i  (fall),
        .model_i (model_i),
        .sw_i    (sw),
        .mode_o  (mode_o),
        .upd_o   (mode_upd_o)
    );

    // R6: a switch update always comes with a write event in the switch block
    assert_sw_with_event_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sw.vld |-> (wr_valid_o && wr_addr_o[15:4] == SW_BLOCK));

endmodule

// File: tb/tb_bus_snoop_capture.sv
module tb_bus_snoop_capture;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;
    localparam logic [7:0] FILL = 8'hEE;
    localparam logic [7:0] BANK = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  model = 2'd1;
    logic        ph0 = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  data = '0;
    logic        rw = 1'b1;
    logic        aux = 1'b0;
    logic        wr_valid, wr_aux, wr_text, mode_upd;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data, mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_snoop_capture dut (
        .clk_i(clk), .rst_ni(rst_n), .model_i(model), .ph0_i(ph0),
        .addr_i(addr), .data_i(data), .rw_i(rw), .aux_i(aux),
        .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .wr_aux_o(wr_aux), .wr_text_o(wr_text), .mode_o(mode), .mode_upd_o(mode_upd)
    );

    typedef struct packed {
        logic [15:0] a;
        logic [7:0]  d;
        logic        x;
        logic        t;
    } ev_t;

    typedef struct {
        int   due;
        int   idx;
        logic val;
    } sch_t;

    ev_t  exp_q[$];
    sch_t sched[$];
    int   checks = 0;
    int   fails = 0;
    int   cyc = 0;
    int   upd_seen = 0;
    int   upd_exp = 0;
    logic [7:0] exp_mode = '0;
    bit   done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual %h expected %h", req, what, act, expv);
        end
    endtask

    // monitor: pops the scoreboard whenever an event appears
    always @(negedge clk) begin
        if (rst_n && mode_upd) upd_seen++;
        if (rst_n && wr_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4", "unexpected event addr", {16'h0, wr_addr}, 32'h0);
            end else begin
                ev_t e;
                e = exp_q.pop_front();
                check({wr_addr, wr_data, wr_aux, wr_text} == e, "R2/R3/R5",
                      "event {addr,data,aux,text}",
                      {6'h0, wr_addr, wr_data, wr_aux, wr_text}, {6'h0, e});
            end
        end
    end

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0; model = m; ph0 = 1'b1; rw = 1'b1; addr = '0; data = '0; aux = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        exp_mode = '0; cyc = 0; sched.delete(); exp_q.delete();
        upd_seen = 0; upd_exp = 0;
        @(negedge clk);
        // R8: outputs cleared by reset
        check({wr_valid, wr_addr, wr_data, wr_aux, wr_text, mode, mode_upd} == '0, "R8",
              "reset outputs", {31'h0, wr_valid} | {24'h0, mode}, 32'h0);
    endtask

    // style 0: clean bus, 1: data settles late, 2: bank byte replaces data after fall
    task automatic bus_cycle(input logic [15:0] a, input logic [7:0] dv, input bit wr,
                             input bit ax, input int style);
        bit   txt, io;
        int   lag;
        ev_t  e;
        sch_t s;
        txt = (a >= 16'h0400) && (a <= 16'h07FF);
        io  = (a[15:8] == 8'hC0);
        lag = (model == 2'd0) ? 2 : 3;
        if (wr && (txt || io)) begin
            e.a = a; e.x = ax; e.t = txt;
            e.d = (style == 1 && model != 2'd0) ? FILL : dv;
            exp_q.push_back(e);
            if (a[15:4] == 12'hC05) begin
                s.due = cyc + lag; s.idx = int'(a[3:1]); s.val = a[0];
                sched.push_back(s);
            end
        end
        @(negedge clk);
        ph0 = 1'b1; addr = a; rw = !wr; aux = ax; data = (style == 1) ? FILL : dv;
        repeat (7) @(negedge clk);
        ph0 = 1'b0;
        for (int n = 1; n <= 8; n++) begin
            @(negedge clk);
            if (n == 3 && style == 2) data = BANK;
            if (n == 4 && style == 1) data = dv;
        end
        for (int i = sched.size() - 1; i >= 0; i--) begin
            if (sched[i].due == cyc) begin
                exp_mode[sched[i].idx] = sched[i].val;
                upd_exp++;
                sched.delete(i);
            end
        end
        // R7/R9: mode follows the scheduled lag
        check(mode == exp_mode, "R7", $sformatf("mode after bus cycle %0d", cyc),
              {24'h0, mode}, {24'h0, exp_mode});
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) bus_cycle(16'h0000, 8'h00, 1'b0, 1'b0, 0);
    endtask

    task automatic drain(input string tag);
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, tag, "events still expected", exp_q.size(), 0);
        check(upd_seen == upd_exp, "R7", "mode update pulses", upd_seen, upd_exp);
    endtask

    initial begin
        // later 8-bit host: edge capture, window decode, lag 3
        do_reset(2'd1);
        bus_cycle(16'h0400, 8'hA5, 1'b1, 1'b0, 0);   // R5 main text
        bus_cycle(16'h07FF, 8'h3C, 1'b1, 1'b1, 0);   // R5 aux text
        bus_cycle(16'h0800, 8'h11, 1'b1, 1'b0, 0);   // R4 outside
        bus_cycle(16'h03FF, 8'h22, 1'b1, 1'b0, 0);   // R4 below text
        bus_cycle(16'h0500, 8'h33, 1'b0, 1'b0, 0);   // R4 read ignored
        bus_cycle(16'hC010, 8'h44, 1'b1, 1'b0, 0);   // R4 I/O page, no switch
        bus_cycle(16'hC053, 8'h00, 1'b1, 1'b0, 0);   // R6 bit1 <- 1, data ignored
        idle(4);
        bus_cycle(16'hC055, 8'hFF, 1'b1, 1'b0, 0);   // R9 back to back
        bus_cycle(16'hC057, 8'hFF, 1'b1, 1'b0, 0);
        bus_cycle(16'hC052, 8'hFF, 1'b1, 1'b0, 0);
        idle(4);
        bus_cycle(16'h0450, 8'h3C, 1'b1, 1'b0, 1);   // R2 late data missed at edge
        drain("R4");

        // early host: delayed capture, lag 2
        do_reset(2'd0);
        bus_cycle(16'h0450, 8'h3C, 1'b1, 1'b0, 1);   // R3 late data captured
        bus_cycle(16'h06A0, 8'h81, 1'b1, 1'b1, 1);   // R3 aux, late
        bus_cycle(16'hC051, 8'h00, 1'b1, 1'b0, 0);   // R6 bit0 <- 1
        bus_cycle(16'hC05F, 8'h00, 1'b1, 1'b0, 0);   // R9 consecutive, bit7 <- 1
        idle(3);
        bus_cycle(16'h0600, 8'h77, 1'b0, 1'b0, 1);   // R4 read ignored
        drain("R3");

        // 16-bit host: bank byte after fall must not be captured
        do_reset(2'd2);
        bus_cycle(16'h0410, 8'hC3, 1'b1, 1'b0, 2);   // R2
        bus_cycle(16'hC05D, 8'h00, 1'b1, 1'b1, 2);   // R6 bit6 <- 1, R2
        idle(4);
        drain("R2");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule